// File: doc/BRIEF.md
# Manchester Receive Decoder to Nibbles

This block recovers data from a single-wire Manchester-coded receive stream at 10 Mbps. It runs on a sampling clock at eight times the bit rate, nominally 80 MHz. The line input passes through a synchroniser before any edge is examined. Each bit carries a guaranteed transition at its centre, and the block locks its bit timing to those centre transitions. Transitions that fall between two bits of differing value are recognised by their position and discarded.

Decoded bits appear as a one-cycle bit tick with the bit value. This separates the recovered bit timing from the data. The bits are also gathered four at a time into nibbles, one nibble per four bit times (2.5 MHz at 10 Mbps), each marked by a one-cycle valid strobe. A receive-active flag rises on the first transition after a quiet line. It falls when the line stops toggling, and any half-built nibble is then thrown away.

Top module: `mrx_decoder`

## Requirements
- R1: A rising line transition at a bit centre decodes as 1, and a falling one decodes as 0.
- R2: Bits are packed least significant bit first: the first bit of a group lands in `rx_nibble[0]` and the fourth in `rx_nibble[3]`. `rx_nibble_vld` is high for exactly one sample clock per completed nibble.
- R3: `rx_bit_tick` pulses for one sample clock per decoded bit, with `rx_bit` holding that bit. Ticks occur only while `rx_active` is high.
- R4: While active, a transition that comes fewer than 6 samples after the last accepted centre transition is a boundary transition and is ignored. A transition 6 or more samples after it is accepted as a centre transition.
- R5: When the block is inactive, the first transition is taken as a bit centre, and `rx_active` rises.
- R6: If more than 12 samples pass with no transition, `rx_active` falls and any partial nibble is discarded. The next stream then starts a fresh nibble at bit position 0.
- R7: Two transitions 13 samples apart, with 12 quiet samples between them, keep `rx_active` high.
- R8: During reset, all outputs are 0.
- R9: A centre transition moved one sample late still decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, eight samples per bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Manchester-coded receive line, asynchronous |
| rx_bit_tick | output | 1 | One-cycle pulse per recovered bit |
| rx_bit | output | 1 | Value of the recovered bit, valid with the tick |
| rx_nibble | output | 4 | Assembled nibble, first bit in bit 0 |
| rx_nibble_vld | output | 1 | One-cycle strobe when a nibble completes |
| rx_active | output | 1 | High while a stream is being received |

## Verification
The hardest conditions to reach are the ones at the edges of the guard and quiet windows. These are a transition exactly 5 or exactly 6 samples after an accepted centre, and line gaps of exactly 13 or 14 samples. Legal Manchester data never produces any of them. The bench therefore drives hand-shaped waveforms sample by sample, in addition to encoded streams. A partial nibble cut off by silence is followed at once by a full stream. This shows that the next nibble starts fresh at bit 0.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    // Classification of what the line did in one sample period.
    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_CENTRE  = 2'd1,
        EV_BORDER  = 2'd2,
        EV_SILENCE = 2'd3
    } mrx_event_e;

endpackage

// File: rtl/mrx_line_sync.sv
module mrx_line_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic toggle_o,
    output logic level_o
);
    localparam int unsigned TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] pipe;
        logic                   last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.pipe = {sync_q.pipe[SYNC_STAGES-2:0], line_i};
        sync_d.last = sync_q.pipe[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level_o  = sync_q.pipe[TOP];
    assign toggle_o = sync_q.pipe[TOP] ^ sync_q.last;

endmodule

// File: rtl/mrx_bit_recover.sv
module mrx_bit_recover
    import mrx_pkg::*;
#(
    parameter int unsigned GUARD      = 6,
    parameter int unsigned IDLE_LIMIT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    input  logic level_i,
    output logic bit_stb_o,
    output logic bit_o,
    output logic active_o,
    output logic flush_o
);
    localparam int unsigned      CW      = $clog2(IDLE_LIMIT + 2);
    localparam logic [CW-1:0]    CNT_MAX = '1;
    localparam logic [CW-1:0]    GUARD_C = CW'(GUARD);
    localparam logic [CW-1:0]    IDLE_C  = CW'(IDLE_LIMIT);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] gap;
        logic [CW-1:0] quiet;
        logic          stb;
        logic          bitv;
        logic          flush;
    } rec_t;

    rec_t       rec_d, rec_q;
    mrx_event_e ev;

    always_comb begin
        ev = EV_NONE;
        if (toggle_i) begin
            if (!rec_q.active || rec_q.gap >= GUARD_C) ev = EV_CENTRE;
            else                                         ev = EV_BORDER;
        end else if (rec_q.active && rec_q.quiet > IDLE_C) begin
            ev = EV_SILENCE;
        end
    end

    always_comb begin
        rec_d       = rec_q;
        rec_d.stb   = 1'b0;
        rec_d.flush = 1'b0;
        if (rec_q.gap   != CNT_MAX) rec_d.gap   = rec_q.gap + 1'b1;
        if (rec_q.quiet != CNT_MAX) rec_d.quiet = rec_q.quiet + 1'b1;
        unique case (ev)
            EV_CENTRE: begin
                rec_d.active = 1'b1;
                rec_d.stb    = 1'b1;
                rec_d.bitv   = level_i;
                rec_d.gap    = CW'(1);
                rec_d.quiet  = CW'(1);
            end
            EV_BORDER: begin
                rec_d.quiet  = CW'(1);
            end
            EV_SILENCE: begin
                rec_d.active = 1'b0;
                rec_d.flush  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign bit_stb_o = rec_q.stb;
    assign bit_o     = rec_q.bitv;
    assign active_o  = rec_q.active;
    assign flush_o   = rec_q.flush;

    AST_TICK_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_q.stb |-> rec_q.active); // R3
    AST_CENTRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q.stb && $past(rec_q.active)) |-> ($past(rec_q.gap) >= GUARD_C)); // R4
    AST_DROP_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rec_q.active) |-> rec_q.flush); // R6
    AST_SHORT_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q.active && rec_q.quiet <= IDLE_C) |=> rec_q.active); // R7

endmodule

// File: rtl/mrx_nibble_pack.sv
module mrx_nibble_pack #(
    parameter int unsigned NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb_i,
    input  logic             bit_i,
    input  logic             flush_i,
    output logic [NIB_W-1:0] nibble_o,
    output logic             vld_o
);
    localparam int unsigned      PW   = $clog2(NIB_W);
    localparam logic [PW-1:0]    LAST = PW'(NIB_W - 1);

    typedef struct packed {
        logic [PW-1:0]    pos;
        logic [NIB_W-1:0] acc;
        logic [NIB_W-1:0] nib;
        logic             vld;
    } pack_t;

    pack_t            pk_d, pk_q;
    logic [NIB_W-1:0] merged;

    always_comb begin
        merged         = pk_q.acc;
        merged[pk_q.pos] = bit_i;
        pk_d           = pk_q;
        pk_d.vld       = 1'b0;
        if (flush_i) begin
            pk_d.pos = '0;
            pk_d.acc = '0;
        end else if (bit_stb_i) begin
            if (pk_q.pos == LAST) begin
                pk_d.nib = merged;
                pk_d.vld = 1'b1;
                pk_d.pos = '0;
                pk_d.acc = '0;
            end else begin
                pk_d.acc = merged;
                pk_d.pos = pk_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign nibble_o = pk_q.nib;
    assign vld_o    = pk_q.vld;

    AST_NIB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pk_q.vld |=> !pk_q.vld); // R2
    AST_NIB_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        pk_q.vld |-> $past(bit_stb_i)); // R2
    AST_FLUSH_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (pk_q.pos == '0)); // R6

endmodule

// File: rtl/mrx_decoder.sv
module mrx_decoder #(
    parameter int unsigned SAMPLES_PER_BIT = 8,
    parameter int unsigned NIB_W           = 4,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    output logic             rx_bit_tick,
    output logic             rx_bit,
    output logic [NIB_W-1:0] rx_nibble,
    output logic             rx_nibble_vld,
    output logic             rx_active
);
    localparam int unsigned GUARD      = (SAMPLES_PER_BIT * 3) / 4;
    localparam int unsigned IDLE_LIMIT = (SAMPLES_PER_BIT * 3) / 2;

    logic toggle, level, flush;

    mrx_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (rx_line),
        .toggle_o (toggle),
        .level_o  (level)
    );

    mrx_bit_recover #(.GUARD(GUARD), .IDLE_LIMIT(IDLE_LIMIT)) u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .toggle_i  (toggle),
        .level_i   (level),
        .bit_stb_o (rx_bit_tick),
        .bit_o     (rx_bit),
        .active_o  (rx_active),
        .flush_o   (flush)
    );

    mrx_nibble_pack #(.NIB_W(NIB_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb_i (rx_bit_tick),
        .bit_i     (rx_bit),
        .flush_i   (flush),
        .nibble_o  (rx_nibble),
        .vld_o     (rx_nibble_vld)
    );

    AST_VLD_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_nibble_vld |-> $past(rx_active)); // R6

endmodule

// File: tb/sim_mrx_decoder.sv
`timescale 1ns/1ps
module sim_mrx_decoder;
    localparam real HALF = 2.5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b0;
    logic       rx_bit_tick, rx_bit, rx_nibble_vld, rx_active;
    logic [3:0] rx_nibble;

    int checks = 0;
    int fails  = 0;
    logic       tick_bits [64];
    logic [3:0] nibs [64];
    int tick_n = 0, nib_n = 0, fall_n = 0;
    logic prev_act = 1'b0;

    // bit 16 selects a late (sample 5) centre on odd bits; bit 0 = 1, bit 15 = 0
    localparam logic [16:0] VEC [8] = '{
        17'h01235, 17'h00001, 17'h07FFF, 17'h05555,
        17'h02AAB, 17'h04C39, 17'h00F0F, 17'h13A5D
    };

    always #(HALF) clk = ~clk;

    mrx_decoder u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .rx_bit_tick(rx_bit_tick), .rx_bit(rx_bit),
        .rx_nibble(rx_nibble), .rx_nibble_vld(rx_nibble_vld),
        .rx_active(rx_active)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_bit_tick && tick_n < 64) begin tick_bits[tick_n] = rx_bit; tick_n++; end
            if (rx_nibble_vld && nib_n < 64) begin nibs[nib_n] = rx_nibble; nib_n++; end
            if (prev_act && !rx_active) fall_n++;
            prev_act = rx_active;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic lv, input int n);
        rx_line = lv;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b, input int first);
        hold(~b, first);
        hold(b, 8 - first);
    endtask

    task automatic clear_log();
        @(negedge clk);
        tick_n = 0; nib_n = 0; fall_n = 0;
    endtask

    initial begin
        #(HALF * 2 * 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!rx_bit_tick && !rx_nibble_vld && !rx_active && rx_nibble == 4'h0 && !rx_bit,
            "R8 reset outputs", int'({rx_bit_tick, rx_nibble_vld, rx_active, rx_bit}), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // table-driven streams: R1, R2, R3, R5, R6, R9
        for (int v = 0; v < 8; v++) begin
            clear_log();
            for (int i = 0; i < 16; i++)
                send_bit(VEC[v][i], (VEC[v][16] && (i % 2 == 1)) ? 5 : 4);
            chk(rx_active == 1'b1, "R5 active during stream", int'(rx_active), 1);
            hold(1'b0, 20);
            @(negedge clk);
            chk(rx_active == 1'b0, "R6 active drops after silence", int'(rx_active), 0);
            chk(tick_n == 16, VEC[v][16] ? "R9 tick count jittered" : "R3 tick count", tick_n, 16);
            for (int i = 0; i < 16; i++)
                if (i < tick_n)
                    chk(tick_bits[i] == VEC[v][i], VEC[v][16] ? "R9 bit value" : "R1 bit value",
                        int'(tick_bits[i]), int'(VEC[v][i]));
            chk(nib_n == 4, "R2 nibble count", nib_n, 4);
            for (int k = 0; k < 4; k++)
                if (k < nib_n)
                    chk(nibs[k] == VEC[v][4*k +: 4], "R2 nibble LSB first",
                        int'(nibs[k]), int'(VEC[v][4*k +: 4]));
        end

        // R6: partial nibble discarded, next stream aligned at bit 0
        clear_log();
        send_bit(1, 4); send_bit(0, 4); send_bit(1, 4);
        send_bit(1, 4); send_bit(0, 4); send_bit(0, 4);
        hold(1'b0, 20);
        @(negedge clk);
        chk(nib_n == 1, "R6 partial discarded count", nib_n, 1);
        chk(nibs[0] == 4'hD, "R6 first nibble", int'(nibs[0]), 13);
        clear_log();
        for (int i = 0; i < 16; i++) send_bit(VEC[0][i], 4);
        hold(1'b0, 20);
        @(negedge clk);
        chk(nib_n == 4 && nibs[0] == 4'h5 && nibs[3] == 4'h1, "R6 fresh alignment",
            int'(nibs[0]), 5);

        // R4: boundary at 5 samples ignored, centre at 6 samples accepted
        clear_log();
        hold(1'b1, 5); hold(1'b0, 3); hold(1'b1, 6); hold(1'b0, 20);
        @(negedge clk);
        chk(tick_n == 3, "R4 guard tick count", tick_n, 3);
        chk(tick_bits[0] == 1'b1 && tick_bits[1] == 1'b1 && tick_bits[2] == 1'b0,
            "R4 guard bit values", int'({tick_bits[0], tick_bits[1], tick_bits[2]}), 6);
        chk(nib_n == 0, "R4 no nibble", nib_n, 0);

        // R7: transitions 13 samples apart keep the stream alive
        clear_log();
        hold(1'b1, 13); hold(1'b0, 4);
        @(negedge clk);
        chk(rx_active == 1'b1 && fall_n == 0, "R7 active across 12 quiet", fall_n, 0);
        hold(1'b0, 20);
        @(negedge clk);
        chk(tick_n == 2 && tick_bits[0] == 1'b1 && tick_bits[1] == 1'b0, "R7 two bits", tick_n, 2);

        // R6: transitions 14 samples apart end the stream before the second one
        clear_log();
        hold(1'b1, 14); hold(1'b0, 20);
        @(negedge clk);
        chk(fall_n == 2, "R6 drop at 13 quiet", fall_n, 2);
        chk(tick_n == 2 && nib_n == 0, "R6 reacquire after drop", tick_n, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule